// File: doc/BRIEF.md
# Transceiver Channel Loopback Steering

This block steers data for one channel of a multi-gigabit transceiver during self-test. A two-bit mode input picks among three paths. In normal operation, the external parallel transmit byte and its three control bits go to the 8B/10B encoder input. In parallel loopback, the receive-side byte is turned back toward the encoder instead. In serial loopback, the serializer's bit stream is routed into the clock-recovery input instead of the external serial receive lines.

In parallel loopback the block has to build the encoder's control bits itself, because the receive side has no word-sync or special-character-enable signal to loop back. The control/data select is derived from the 3-bit receive link status. If the link reports loss of signal or resynchronisation, an IDLE character (K28.5) is sent in place of the received byte. In every other state, the received byte passes through and the control/data select follows the received special-character flag. A received character flagged with a disparity error, an out-of-band condition or a buffer underflow/overflow is therefore returned as an ordinary character. The encoder-side word is registered on the reference clock. The serial routing is combinational, and the two external serial transmit outputs always carry the serializer stream.

Top module: `lbk_loopback_ctrl`

## Requirements
- R1: A synchronous reset (rst high at a rising clk edge) clears enc_chr_o, enc_ctl_o, enc_wsync_o and enc_spec_o to 0 at that edge, whatever the other inputs are.
- R2: With lb_mode_i = 2'b00 (normal) or 2'b10 (serial loopback), the encoder outputs equal tx_chr_i, tx_ctl_i, tx_wsync_i and tx_spec_i as sampled at the previous rising edge.
- R3: The mode code 2'b11 behaves exactly like 2'b00: the encoder outputs take the external transmit inputs one edge later.
- R4: With lb_mode_i = 2'b01 (parallel loopback), enc_wsync_o is 0 and enc_spec_o is 1 one edge later, whatever tx_wsync_i and tx_spec_i are.
- R5: In parallel loopback with rx_stat_i equal to 3'd1 (loss of signal) or 3'd2 (resync), the next edge gives enc_chr_o = 8'hBC and enc_ctl_o = 1, whatever rx_chr_i and rx_kflag_i are.
- R6: In parallel loopback with any other rx_stat_i, the next edge gives enc_chr_o = rx_chr_i and enc_ctl_o = rx_kflag_i. The other codes are 3'd0 normal, 3'd3 disparity error, 3'd4 out-of-band and 3'd5 underflow/overflow, so characters with those conditions are returned as received.
- R7: With lb_mode_i = 2'b10, cdr_in_o equals ser_tx_i in the same cycle.
- R8: With lb_mode_i other than 2'b10, cdr_in_o equals ser_rx_ext_i in the same cycle.
- R9: prim_tx_o and red_tx_o equal ser_tx_i in every mode.
- R10: A change of lb_mode_i takes effect on the encoder outputs at the very next rising edge, with no extra settling cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| lb_mode_i | input | 2 | Loopback mode select |
| tx_chr_i | input | 8 | External transmit byte |
| tx_ctl_i | input | 1 | External control/data select |
| tx_wsync_i | input | 1 | External word-sync enable |
| tx_spec_i | input | 1 | External special-character enable |
| rx_chr_i | input | 8 | Received byte from the elastic buffer |
| rx_kflag_i | input | 1 | Received special-character flag |
| rx_stat_i | input | 3 | Receive link status code |
| ser_tx_i | input | SER_W | Serializer output stream |
| ser_rx_ext_i | input | SER_W | External serial receive input |
| enc_chr_o | output | 8 | Byte to the encoder |
| enc_ctl_o | output | 1 | Control/data select to the encoder |
| enc_wsync_o | output | 1 | Word-sync enable to the encoder |
| enc_spec_o | output | 1 | Special-character enable to the encoder |
| cdr_in_o | output | SER_W | Clock-recovery input |
| prim_tx_o | output | SER_W | Primary serial transmit output |
| red_tx_o | output | SER_W | Redundant serial transmit output |

## Verification
On every cycle, the assertions compare each registered encoder output with the inputs sampled one edge earlier, according to the mode and link status sampled with them. They cover the IDLE substitution, the forced control bits, the passthrough of the transmit inputs and the post-reset zeros. They also check the combinational routing of the clock-recovery input and the two serial transmit outputs. Only the bench scenarios show the sequences: switching modes back to back, walking through every link status code inside parallel loopback, and checking that a reserved mode code or a busy set of transmit inputs does not disturb these relations.

// File: rtl/lbk_pkg.sv
package lbk_pkg;
    localparam int CHR_W  = 8;
    localparam int STAT_W = 3;
    localparam int MODE_W = 2;

    typedef enum logic [MODE_W-1:0] {
        LB_OFF = 2'b00,
        LB_PAR = 2'b01,
        LB_SER = 2'b10,
        LB_RSV = 2'b11
    } lb_mode_e;

    typedef enum logic [STAT_W-1:0] {
        LS_NORMAL = 3'd0,
        LS_LOS    = 3'd1,
        LS_RESYNC = 3'd2,
        LS_DISP   = 3'd3,
        LS_OOB    = 3'd4,
        LS_UOFLOW = 3'd5
    } link_st_e;

    localparam logic [CHR_W-1:0] IDLE_CHR = 8'hBC;

    typedef struct packed {
        logic [CHR_W-1:0] chr;
        logic             ctl;
        logic             wsync;
        logic             spec;
    } tx_word_t;
endpackage

// File: rtl/lbk_mode_decode.sv
module lbk_mode_decode
    import lbk_pkg::*;
(
    input  logic [MODE_W-1:0] mode_i,
    output logic              par_o,
    output logic              ser_o
);
    always_comb begin
        par_o = 1'b0;
        ser_o = 1'b0;
        case (lb_mode_e'(mode_i))
            LB_PAR:  par_o = 1'b1;
            LB_SER:  ser_o = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/lbk_par_source.sv
module lbk_par_source
    import lbk_pkg::*;
(
    input  logic [CHR_W-1:0]  rx_chr_i,
    input  logic              rx_kflag_i,
    input  logic [STAT_W-1:0] rx_stat_i,
    output tx_word_t          word_o
);
    logic link_down;

    always_comb begin
        link_down    = (rx_stat_i == LS_LOS) || (rx_stat_i == LS_RESYNC);
        word_o.wsync = 1'b0;
        word_o.spec  = 1'b1;
        if (link_down) begin
            word_o.chr = IDLE_CHR;
            word_o.ctl = 1'b1;
        end else begin
            word_o.chr = rx_chr_i;
            word_o.ctl = rx_kflag_i;
        end
    end
endmodule

// File: rtl/lbk_serial_route.sv
module lbk_serial_route #(
    parameter int SER_W = 1
) (
    input  logic             ser_sel_i,
    input  logic [SER_W-1:0] ser_tx_i,
    input  logic [SER_W-1:0] ser_rx_ext_i,
    output logic [SER_W-1:0] cdr_o,
    output logic [SER_W-1:0] prim_tx_o,
    output logic [SER_W-1:0] red_tx_o
);
    for (genvar gi = 0; gi < SER_W; gi++) begin : g_lane
        assign cdr_o[gi] = ser_sel_i ? ser_tx_i[gi] : ser_rx_ext_i[gi];
    end

    assign prim_tx_o = ser_tx_i;
    assign red_tx_o  = ser_tx_i;
endmodule

// File: rtl/lbk_loopback_ctrl.sv
module lbk_loopback_ctrl
    import lbk_pkg::*;
#(
    parameter int SER_W = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [MODE_W-1:0] lb_mode_i,
    input  logic [CHR_W-1:0]  tx_chr_i,
    input  logic              tx_ctl_i,
    input  logic              tx_wsync_i,
    input  logic              tx_spec_i,
    input  logic [CHR_W-1:0]  rx_chr_i,
    input  logic              rx_kflag_i,
    input  logic [STAT_W-1:0] rx_stat_i,
    input  logic [SER_W-1:0]  ser_tx_i,
    input  logic [SER_W-1:0]  ser_rx_ext_i,
    output logic [CHR_W-1:0]  enc_chr_o,
    output logic              enc_ctl_o,
    output logic              enc_wsync_o,
    output logic              enc_spec_o,
    output logic [SER_W-1:0]  cdr_in_o,
    output logic [SER_W-1:0]  prim_tx_o,
    output logic [SER_W-1:0]  red_tx_o
);
    logic     par_sel;
    logic     ser_sel;
    tx_word_t par_word;
    tx_word_t ext_word;
    tx_word_t word_d, word_q;

    lbk_mode_decode u_dec (
        .mode_i (lb_mode_i),
        .par_o  (par_sel),
        .ser_o  (ser_sel)
    );

    lbk_par_source u_par (
        .rx_chr_i   (rx_chr_i),
        .rx_kflag_i (rx_kflag_i),
        .rx_stat_i  (rx_stat_i),
        .word_o     (par_word)
    );

    lbk_serial_route #(.SER_W(SER_W)) u_ser (
        .ser_sel_i    (ser_sel),
        .ser_tx_i     (ser_tx_i),
        .ser_rx_ext_i (ser_rx_ext_i),
        .cdr_o        (cdr_in_o),
        .prim_tx_o    (prim_tx_o),
        .red_tx_o     (red_tx_o)
    );

    always_comb begin
        ext_word.chr   = tx_chr_i;
        ext_word.ctl   = tx_ctl_i;
        ext_word.wsync = tx_wsync_i;
        ext_word.spec  = tx_spec_i;
        if (rst) begin
            word_d = '0;
        end else if (par_sel) begin
            word_d = par_word;
        end else begin
            word_d = ext_word;
        end
    end

    always_ff @(posedge clk) begin
        word_q <= word_d;
    end

    assign enc_chr_o   = word_q.chr;
    assign enc_ctl_o   = word_q.ctl;
    assign enc_wsync_o = word_q.wsync;
    assign enc_spec_o  = word_q.spec;
endmodule

// File: rtl/lbk_loopback_chk.sv
module lbk_loopback_chk #(
    parameter int SER_W = 1
) (
    input logic             clk,
    input logic             rst,
    input logic [1:0]       lb_mode_i,
    input logic [7:0]       tx_chr_i,
    input logic             tx_ctl_i,
    input logic             tx_wsync_i,
    input logic             tx_spec_i,
    input logic [7:0]       rx_chr_i,
    input logic             rx_kflag_i,
    input logic [2:0]       rx_stat_i,
    input logic [SER_W-1:0] ser_tx_i,
    input logic [SER_W-1:0] ser_rx_ext_i,
    input logic [7:0]       enc_chr_o,
    input logic             enc_ctl_o,
    input logic             enc_wsync_o,
    input logic             enc_spec_o,
    input logic [SER_W-1:0] cdr_in_o,
    input logic [SER_W-1:0] prim_tx_o,
    input logic [SER_W-1:0] red_tx_o
);
    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (enc_chr_o == 8'h00 && !enc_ctl_o && !enc_wsync_o && !enc_spec_o));

    assert_ext_path_R2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && ($past(lb_mode_i) == 2'b00 || $past(lb_mode_i) == 2'b10)) |->
        ({enc_chr_o, enc_ctl_o, enc_wsync_o, enc_spec_o} ==
         $past({tx_chr_i, tx_ctl_i, tx_wsync_i, tx_spec_i})));

    assert_reserved_path_R3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(lb_mode_i) == 2'b11) |->
        ({enc_chr_o, enc_ctl_o, enc_wsync_o, enc_spec_o} ==
         $past({tx_chr_i, tx_ctl_i, tx_wsync_i, tx_spec_i})));

    assert_par_forced_R4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(lb_mode_i) == 2'b01) |-> (!enc_wsync_o && enc_spec_o));

    assert_par_idle_R5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(lb_mode_i) == 2'b01 &&
         ($past(rx_stat_i) == 3'd1 || $past(rx_stat_i) == 3'd2)) |->
        (enc_chr_o == 8'hBC && enc_ctl_o));

    assert_par_pass_R6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(lb_mode_i) == 2'b01 &&
         $past(rx_stat_i) != 3'd1 && $past(rx_stat_i) != 3'd2) |->
        (enc_chr_o == $past(rx_chr_i) && enc_ctl_o == $past(rx_kflag_i)));

    assert_serial_loop_R7: assert property (@(posedge clk) disable iff (rst)
        (lb_mode_i == 2'b10) |-> (cdr_in_o == ser_tx_i));

    assert_serial_ext_R8: assert property (@(posedge clk) disable iff (rst)
        (lb_mode_i != 2'b10) |-> (cdr_in_o == ser_rx_ext_i));

    assert_tx_outputs_R9: assert property (@(posedge clk) disable iff (rst)
        (prim_tx_o == ser_tx_i && red_tx_o == ser_tx_i));
endmodule

bind lbk_loopback_ctrl lbk_loopback_chk #(.SER_W(SER_W)) u_chk (.*);

// File: tb/lbk_loopback_ctrl_test.sv
module lbk_loopback_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int SER_W      = 1;
    localparam int WDOG_CYC   = 20000;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [1:0]       lb_mode_i = 2'b00;
    logic [7:0]       tx_chr_i = 8'h00;
    logic             tx_ctl_i = 1'b0;
    logic             tx_wsync_i = 1'b0;
    logic             tx_spec_i = 1'b0;
    logic [7:0]       rx_chr_i = 8'h00;
    logic             rx_kflag_i = 1'b0;
    logic [2:0]       rx_stat_i = 3'd0;
    logic [SER_W-1:0] ser_tx_i = '0;
    logic [SER_W-1:0] ser_rx_ext_i = '0;
    logic [7:0]       enc_chr_o;
    logic             enc_ctl_o;
    logic             enc_wsync_o;
    logic             enc_spec_o;
    logic [SER_W-1:0] cdr_in_o;
    logic [SER_W-1:0] prim_tx_o;
    logic [SER_W-1:0] red_tx_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    typedef struct {
        logic [10:0] word;
        string       req;
    } exp_item_t;

    exp_item_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    lbk_loopback_ctrl #(.SER_W(SER_W)) uut (
        .clk(clk), .rst(rst), .lb_mode_i(lb_mode_i),
        .tx_chr_i(tx_chr_i), .tx_ctl_i(tx_ctl_i), .tx_wsync_i(tx_wsync_i), .tx_spec_i(tx_spec_i),
        .rx_chr_i(rx_chr_i), .rx_kflag_i(rx_kflag_i), .rx_stat_i(rx_stat_i),
        .ser_tx_i(ser_tx_i), .ser_rx_ext_i(ser_rx_ext_i),
        .enc_chr_o(enc_chr_o), .enc_ctl_o(enc_ctl_o), .enc_wsync_o(enc_wsync_o), .enc_spec_o(enc_spec_o),
        .cdr_in_o(cdr_in_o), .prim_tx_o(prim_tx_o), .red_tx_o(red_tx_o)
    );

    task automatic check(input bit ok, input string req, input logic [10:0] act, input logic [10:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // expected encoder word {chr, ctl, wsync, spec} from the requirements
    function automatic logic [10:0] model(input logic r, input logic [1:0] m,
                                          input logic [7:0] tc, input logic tctl, input logic tws, input logic tsp,
                                          input logic [7:0] rc, input logic rk, input logic [2:0] st);
        if (r) return 11'h000;
        if (m == 2'b01) begin
            if (st == 3'd1 || st == 3'd2) return {8'hBC, 1'b1, 1'b0, 1'b1};
            return {rc, rk, 1'b0, 1'b1};
        end
        return {tc, tctl, tws, tsp};
    endfunction

    task automatic drive(input logic r, input logic [1:0] m,
                         input logic [7:0] tc, input logic tctl, input logic tws, input logic tsp,
                         input logic [7:0] rc, input logic rk, input logic [2:0] st,
                         input logic [SER_W-1:0] stx, input logic [SER_W-1:0] srx, input string req);
        exp_item_t it;
        logic [SER_W-1:0] exp_cdr;
        @(negedge clk);
        rst = r; lb_mode_i = m;
        tx_chr_i = tc; tx_ctl_i = tctl; tx_wsync_i = tws; tx_spec_i = tsp;
        rx_chr_i = rc; rx_kflag_i = rk; rx_stat_i = st;
        ser_tx_i = stx; ser_rx_ext_i = srx;
        it.word = model(r, m, tc, tctl, tws, tsp, rc, rk, st);
        it.req  = req;
        sb_q.push_back(it);
        #1;
        exp_cdr = (m == 2'b10) ? stx : srx;
        check(cdr_in_o == exp_cdr, (m == 2'b10) ? "R7" : "R8", 11'(cdr_in_o), 11'(exp_cdr));
        check(prim_tx_o == stx && red_tx_o == stx, "R9", 11'({prim_tx_o, red_tx_o}), 11'({stx, stx}));
    endtask

    // monitor: compares the registered word one edge after it was driven
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                exp_item_t it;
                it = sb_q.pop_front();
                check({enc_chr_o, enc_ctl_o, enc_wsync_o, enc_spec_o} == it.word, it.req,
                      {enc_chr_o, enc_ctl_o, enc_wsync_o, enc_spec_o}, it.word);
            end
        end
    end

    initial begin
        repeat (WDOG_CYC) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1: reset clears despite busy inputs, in both normal and parallel modes
        drive(1, 2'b00, 8'hFF, 1, 1, 1, 8'h55, 1, 3'd0, 1'b1, 1'b0, "R1");
        drive(1, 2'b01, 8'hA5, 1, 1, 1, 8'h3C, 1, 3'd1, 1'b0, 1'b1, "R1");
        // R2: normal mode passthrough, several patterns
        drive(0, 2'b00, 8'h12, 0, 1, 0, 8'hEE, 1, 3'd1, 1'b1, 1'b0, "R2");
        drive(0, 2'b00, 8'hC3, 1, 0, 1, 8'h00, 0, 3'd0, 1'b0, 1'b1, "R2");
        // R3: reserved code acts as normal
        drive(0, 2'b11, 8'h7E, 1, 1, 0, 8'h99, 0, 3'd2, 1'b1, 1'b1, "R3");
        drive(0, 2'b11, 8'h01, 0, 0, 1, 8'h44, 1, 3'd0, 1'b0, 1'b0, "R3");
        // R10 and R4/R6: switch straight into parallel loopback, normal status
        drive(0, 2'b01, 8'h20, 1, 1, 0, 8'h5A, 0, 3'd0, 1'b1, 1'b0, "R10 R4 R6");
        // R5: LOS and RESYNC produce IDLE
        drive(0, 2'b01, 8'h20, 0, 1, 0, 8'h5A, 0, 3'd1, 1'b0, 1'b1, "R5 LOS");
        drive(0, 2'b01, 8'hFF, 0, 1, 0, 8'h07, 0, 3'd2, 1'b1, 1'b0, "R5 RESYNC");
        // R6: error conditions looped as received
        drive(0, 2'b01, 8'h00, 1, 1, 0, 8'hA1, 0, 3'd3, 1'b1, 1'b1, "R6 disparity");
        drive(0, 2'b01, 8'h00, 1, 1, 0, 8'hB2, 1, 3'd4, 1'b0, 1'b0, "R6 oob");
        drive(0, 2'b01, 8'h00, 1, 1, 0, 8'hBC, 1, 3'd5, 1'b1, 1'b0, "R6 uoflow");
        drive(0, 2'b01, 8'h00, 0, 1, 0, 8'h6D, 1, 3'd0, 1'b0, 1'b1, "R6 kflag");
        // R7 and R10: serial loopback right after parallel, tx still from external inputs
        drive(0, 2'b10, 8'h3F, 1, 0, 1, 8'hBC, 1, 3'd1, 1'b1, 1'b0, "R7 R10 R2");
        drive(0, 2'b10, 8'h80, 0, 1, 1, 8'h11, 0, 3'd2, 1'b0, 1'b1, "R7 R2");
        // R8: back to normal, external rx feeds clock recovery
        drive(0, 2'b00, 8'h4B, 0, 0, 0, 8'h22, 1, 3'd2, 1'b1, 1'b0, "R8 R10");
        // R1: reset in the middle of parallel loopback
        drive(1, 2'b01, 8'h4B, 1, 1, 1, 8'h22, 1, 3'd2, 1'b1, 1'b1, "R1 mid-run");
        drive(0, 2'b01, 8'h4B, 1, 1, 1, 8'hC7, 1, 3'd0, 1'b0, 1'b0, "R4 R6 after reset");
        repeat (3) @(posedge clk);
        #2;
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule